// File: doc/BRIEF.md
# Idle-Load Window Detector

This block judges whether the metered load is too small to count. It watches a stream of signed power words, one per output-word strobe. Over a window whose length is a programmable number of strobes, it adds up the magnitude of each word. When the window closes, it compares that sum with the threshold multiplied by the window length. If the sum is strictly smaller, a registered idle flag is raised. The pulse formatter reads this flag to suppress creep pulses.

Two 24-bit settings control the detector: the window length and the threshold. The threshold is a signed fraction with the binary point just right of the sign bit, and only non-negative values are meaningful. If either setting is zero, or if the threshold is negative, the detector is switched off. While it is off, the flag is held low and the window restarts from empty. Clock cycles without a strobe leave the window untouched.

Top module: `nld_detector`

## Requirements
- R1: After a synchronous reset, `idle_flag` is 0.
- R2: While `win_len` is 0, `idle_flag` is 0 no matter what power words arrive.
- R3: While `thr_lvl` is 0, `idle_flag` is 0 no matter what power words arrive.
- R4: A `thr_lvl` with bit 23 set (negative) is treated as zero, so the detector is switched off and `idle_flag` stays 0.
- R5: The window closes on the strobe that is the `win_len`-th since the window opened. `idle_flag` changes only then, and the new value is visible one clock after that strobe.
- R6: At window close, `idle_flag` becomes 1 when the sum of |`pwr_word`| over the window is strictly less than `thr_lvl` × `win_len`.
- R7: At window close, a sum equal to or above `thr_lvl` × `win_len` makes `idle_flag` 0.
- R8: Power words are summed by magnitude: a negative word adds its absolute value, and 0x800000 (-1.0) adds 2^23.
- R9: Cycles with `word_stb` low neither advance the window nor change the sum.
- R10: Switching the detector off clears `idle_flag` by the next clock and empties the window, so that after it is switched back on, a full window of `win_len` fresh strobes is needed.
- R11: Between window closes, `idle_flag` keeps its last decided value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| word_stb | input | 1 | One-cycle strobe marking a valid power word |
| pwr_word | input | 24 | Signed power sample (two's complement) |
| win_len | input | 24 | Window length in strobes; 0 switches the detector off |
| thr_lvl | input | 24 | Threshold fraction; 0 or negative switches the detector off |
| idle_flag | output | 1 | High when the last closed window was below the threshold |

## Verification
Every result comes out of one register stage. The flag decision is due one clock after the strobe that closes the window. The clearing caused by switching the detector off is due one clock after the setting changes. The bench drives each strobe or setting change at a falling edge and checks `idle_flag` at the next falling edge, so every sample lands half a period after the rising edge that should have produced the change. The bench also checks the flag after strobes and idle cycles that fall short of a window close, to confirm that nothing changes early.

// File: rtl/nld_pkg.sv
package nld_pkg;

    localparam int unsigned NLD_DATA_W = 24;
    localparam int unsigned NLD_CNT_W  = 24;

    typedef struct packed {
        logic active;
        logic close;
    } nld_ctl_t;

endpackage

// File: rtl/nld_window_ctr.sv
module nld_window_ctr #(
    parameter int unsigned CNT_W = nld_pkg::NLD_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic             stb,
    input  logic [CNT_W-1:0] len,
    output logic             close
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   cnt_nx;

    assign cnt_nx = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
    assign close  = active && stb && (cnt_nx >= {1'b0, len});

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            cnt_q <= '0;
        end else if (close) begin
            cnt_q <= '0;
        end else if (stb) begin
            cnt_q <= cnt_nx[CNT_W-1:0];
        end
    end

    AST_CNT_EMPTY_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !active |=> (cnt_q == '0)); // R10
    AST_CNT_HOLD_NO_STB: assert property (@(posedge clk) disable iff (rst)
        active && !stb |=> $stable(cnt_q)); // R9

endmodule

// File: rtl/nld_accum.sv
module nld_accum #(
    parameter int unsigned DATA_W = nld_pkg::NLD_DATA_W,
    parameter int unsigned ACC_W  = 48
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic              stb,
    input  logic              close,
    input  logic [DATA_W-1:0] word,
    output logic [ACC_W-1:0]  sum
);
    logic [ACC_W-1:0]  acc_q;
    logic [DATA_W-1:0] mag;

    assign mag = word[DATA_W-1] ? (~word + {{(DATA_W-1){1'b0}}, 1'b1}) : word;
    assign sum = acc_q + {{(ACC_W-DATA_W){1'b0}}, mag};

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            acc_q <= '0;
        end else if (close) begin
            acc_q <= '0;
        end else if (stb) begin
            acc_q <= sum;
        end
    end

    AST_ACC_CLEAR_AT_CLOSE: assert property (@(posedge clk) disable iff (rst)
        close |=> (acc_q == '0)); // R5
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        active && stb |-> (sum >= acc_q)); // R8
    AST_ACC_HOLD_NO_STB: assert property (@(posedge clk) disable iff (rst)
        active && !stb |=> $stable(acc_q)); // R9

endmodule

// File: rtl/nld_detector.sv
module nld_detector #(
    parameter int unsigned DATA_W = nld_pkg::NLD_DATA_W,
    parameter int unsigned CNT_W  = nld_pkg::NLD_CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              word_stb,
    input  logic [DATA_W-1:0] pwr_word,
    input  logic [CNT_W-1:0]  win_len,
    input  logic [DATA_W-1:0] thr_lvl,
    output logic              idle_flag
);
    import nld_pkg::*;

    localparam int unsigned ACC_W = DATA_W + CNT_W;

    logic [DATA_W-1:0] thr_eff;
    logic [ACC_W-1:0]  limit;
    logic [ACC_W-1:0]  sum;
    nld_ctl_t          ctl;
    logic              flag_q;

    // negative threshold behaves as zero
    assign thr_eff    = thr_lvl[DATA_W-1] ? '0 : thr_lvl;
    assign ctl.active = (win_len != '0) && (thr_eff != '0);
    assign limit      = ACC_W'(thr_eff) * ACC_W'(win_len);

    nld_window_ctr #(.CNT_W(CNT_W)) u_win (
        .clk    (clk),
        .rst    (rst),
        .active (ctl.active),
        .stb    (word_stb),
        .len    (win_len),
        .close  (ctl.close)
    );

    nld_accum #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_acc (
        .clk    (clk),
        .rst    (rst),
        .active (ctl.active),
        .stb    (word_stb),
        .close  (ctl.close),
        .word   (pwr_word),
        .sum    (sum)
    );

    always_ff @(posedge clk) begin
        if (rst || !ctl.active) begin
            flag_q <= 1'b0;
        end else if (ctl.close) begin
            flag_q <= (sum < limit);
        end
    end

    assign idle_flag = flag_q;

    AST_FLAG_LOW_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !ctl.active |=> !idle_flag); // R2
    AST_FLAG_HOLD_MID_WINDOW: assert property (@(posedge clk) disable iff (rst)
        ctl.active && !ctl.close |=> $stable(idle_flag)); // R11
    AST_CLOSE_NEEDS_STB: assert property (@(posedge clk) disable iff (rst)
        ctl.close |-> word_stb); // R5

endmodule

// File: tb/sim_nld_detector.sv
module sim_nld_detector;

    logic        clk = 1'b0;
    logic        rst;
    logic        word_stb;
    logic [23:0] pwr_word;
    logic [23:0] win_len;
    logic [23:0] thr_lvl;
    logic        idle_flag;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    nld_detector u0 (
        .clk       (clk),
        .rst       (rst),
        .word_stb  (word_stb),
        .pwr_word  (pwr_word),
        .win_len   (win_len),
        .thr_lvl   (thr_lvl),
        .idle_flag (idle_flag)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: idle_flag=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic strobe(input logic [23:0] p);
        @(negedge clk);
        word_stb = 1'b1;
        pwr_word = p;
        @(negedge clk);
        word_stb = 1'b0;
        pwr_word = '0;
    endtask

    task automatic setcfg(input logic [23:0] len, input logic [23:0] thr);
        @(negedge clk);
        win_len = len;
        thr_lvl = thr;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 reset", idle_flag, 1'b0);
    endtask

    task automatic t_below_and_equal();
        setcfg(24'd4, 24'd100);
        strobe(24'd10); strobe(24'd20); strobe(24'd30);
        chk("R5 no change before close", idle_flag, 1'b0);
        strobe(-24'sd5);
        chk("R6 sum 65 < 400", idle_flag, 1'b1);
        strobe(24'd100); strobe(24'd100);
        chk("R11 hold mid window", idle_flag, 1'b1);
        strobe(24'd100);
        chk("R11 hold before close", idle_flag, 1'b1);
        strobe(24'd100);
        chk("R7 sum 400 == limit", idle_flag, 1'b0);
    endtask

    task automatic t_magnitude();
        setcfg(24'd2, 24'd4);
        strobe(-24'sd5); strobe(-24'sd5);
        chk("R8 negatives by magnitude", idle_flag, 1'b0);
        setcfg(24'd1, 24'h7FFFFF);
        strobe(24'd0);
        chk("R6 zero power below max thr", idle_flag, 1'b1);
        strobe(24'h800000);
        chk("R8 -1.0 adds 2^23", idle_flag, 1'b0);
    endtask

    task automatic t_gaps();
        setcfg(24'd3, 24'd10);
        strobe(24'd500); strobe(24'd0); strobe(24'd0);
        chk("R7 high window", idle_flag, 1'b0);
        strobe(24'd0); idle(5); strobe(24'd0); idle(7);
        chk("R9 idle cycles do not close", idle_flag, 1'b0);
        strobe(24'd0);
        chk("R9 close on third strobe", idle_flag, 1'b1);
    endtask

    task automatic t_off_modes();
        setcfg(24'd1, 24'd10);
        strobe(24'd0);
        chk("R6 flag set", idle_flag, 1'b1);
        setcfg(24'd0, 24'd10);
        @(negedge clk);
        chk("R10 off clears flag", idle_flag, 1'b0);
        strobe(24'd0); strobe(24'd0);
        chk("R2 win_len zero", idle_flag, 1'b0);
        setcfg(24'd1, 24'd0);
        strobe(24'd0); strobe(24'd0);
        chk("R3 thr zero", idle_flag, 1'b0);
        setcfg(24'd1, 24'h800010);
        strobe(24'd0); strobe(24'd0);
        chk("R4 negative thr", idle_flag, 1'b0);
    endtask

    task automatic t_restart();
        setcfg(24'd3, 24'd10);
        strobe(24'd5); strobe(24'd5);
        setcfg(24'd3, 24'd0);
        @(negedge clk);
        setcfg(24'd3, 24'd10);
        strobe(24'd8);
        chk("R10 counter emptied", idle_flag, 1'b0);
        strobe(24'd8);
        chk("R10 still open", idle_flag, 1'b0);
        strobe(24'd8);
        chk("R10 sum emptied 24 < 30", idle_flag, 1'b1);
    endtask

    initial begin
        rst = 1'b1; word_stb = 1'b0; pwr_word = '0; win_len = '0; thr_lvl = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_below_and_equal();
        t_magnitude();
        t_gaps();
        t_off_modes();
        t_restart();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule